// File: doc/BRIEF.md
# Machine Status Register with Write Legalization

This block holds the machine-level status register of a 64-bit core together with the current privilege level. Software writes go through one write port. The block repairs each write before it stores it. The fields that name a previous privilege only ever hold a mode that the core implements. A field for an absent mode stays frozen. The two width fields always report 64-bit operation. The summary dirty bit follows the floating-point state field. Bits with no assigned meaning always read as zero.

Three static configuration inputs describe the core: whether user mode is implemented, whether supervisor mode is implemented, and whether a custom extension-state field is present. The same legalization rule applies to the current-privilege register when the core changes mode. The block raises a one-cycle address-translation flush request after any write to the status register and after any privilege change. The read port shows the stored value directly. Configuration inputs are expected to change only while reset is asserted.

Top module: `mstat_csr`

## Requirements
- R1: While `rst_n` is low, each rising clock edge loads the register with `64'h0000_000A_0000_1800`. This value has MPP (bits 12:11) = 3, UXL (bits 33:32) = 2'b10, SXL (bits 35:34) = 2'b10, and every other bit 0. The same edge loads `priv_cur` = 3 (machine) and clears `tlb_flush`.
- R2: Privilege legalization uses the codes user = 0, supervisor = 1, reserved = 2 and machine = 3. Without user mode, every request becomes 3. With user mode, a request for 2 becomes 0, and a request for 1 becomes 0 when supervisor mode is absent. Every other request is kept. A write on `priv_we` stores the legalized `priv_wdata` in `priv_cur`.
- R3: A status write stores the legalized form of `csr_wdata[12:11]` in MPP (bits 12:11). It never stores the raw bits.
- R4: SPP (bit 8) takes `csr_wdata[8]` only when `cfg_has_super` is 1. Otherwise it keeps its old value, which is 0 from reset.
- R5: A status write copies the following fields from `csr_wdata`: SIE[1], MIE[3], SPIE[5], MPIE[7], FS[14:13], MPRV[17], SUM[18], MXR[19], TVM[20], TW[21] and TSR[22].
- R6: XS (bits 16:15) takes `csr_wdata[16:15]` only when `cfg_ext_xs` is 1. Otherwise it keeps its old value, which is 0 from reset.
- R7: After every write, SD (bit 63) reads 1 exactly when FS reads 2'b11. The written value of bit 63 is ignored.
- R8: UXL (bits 33:32) and SXL (bits 35:34) always read 2'b10, whatever value is written.
- R9: `tlb_flush` is 1 in the cycle after an edge that sampled `csr_we` or `priv_we` high. It is 0 after an edge where both were low.
- R10: Every bit outside the fields named in R1 to R8 reads 0, including after a write of all ones.
- R11: When `csr_we` is low, the status value does not change. When `priv_we` is low, `priv_cur` does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_has_user | input | 1 | User mode is implemented |
| cfg_has_super | input | 1 | Supervisor mode is implemented |
| cfg_ext_xs | input | 1 | Custom extension-state field is present |
| csr_we | input | 1 | Status register write strobe |
| csr_wdata | input | 64 | Status register write data |
| csr_rdata | output | 64 | Current status register contents |
| priv_we | input | 1 | Current-privilege write strobe |
| priv_wdata | input | 2 | Requested privilege level |
| priv_cur | output | 2 | Current (legalized) privilege level |
| tlb_flush | output | 1 | One-cycle address-translation flush request |

## Verification
On every cycle, the bound checker verifies these invariants: both privilege values hold only legal modes for the configuration, the dirty summary agrees with FS, the width fields read 2'b10, undefined bits read zero, SPP stays zero without supervisor mode, the flush follows the write strobes one cycle later, and the register holds when no write is presented. The checker cannot show that a write lands in the correct field, that a reserved or absent-mode request maps to the correct replacement code, or how the XS gate and the SPP gate behave under each configuration. The bench scenarios cover these points. They replay all-ones, alternating-bit and targeted writes under three configurations and compare every cycle against an independent model.

// File: rtl/mstat_pkg.sv
// Package: mstat_pkg
// Shared encodings, field positions and derived masks for the machine
// status register. Assumes a 64-bit register layout; positions are fixed
// because software decodes them.
package mstat_pkg;

    localparam int unsigned PRIV_W  = 2;
    localparam int unsigned STAT_W  = 64;
    localparam int unsigned XLFLD_W = 2;

    typedef enum logic [PRIV_W-1:0] {
        PRIV_USER  = 2'd0,
        PRIV_SUPER = 2'd1,
        PRIV_RSVD  = 2'd2,
        PRIV_MACH  = 2'd3
    } priv_e;

    typedef struct packed {
        logic has_user;
        logic has_super;
        logic ext_xs;
    } mstat_cfg_t;

    // Field least-significant bit positions
    localparam int unsigned POS_SIE  = 1;
    localparam int unsigned POS_MIE  = 3;
    localparam int unsigned POS_SPIE = 5;
    localparam int unsigned POS_MPIE = 7;
    localparam int unsigned POS_SPP  = 8;
    localparam int unsigned POS_MPP  = 11;
    localparam int unsigned POS_FS   = 13;
    localparam int unsigned POS_XS   = 15;
    localparam int unsigned POS_MPRV = 17;
    localparam int unsigned POS_SUM  = 18;
    localparam int unsigned POS_MXR  = 19;
    localparam int unsigned POS_TVM  = 20;
    localparam int unsigned POS_TW   = 21;
    localparam int unsigned POS_TSR  = 22;
    localparam int unsigned POS_UXL  = 32;
    localparam int unsigned POS_SXL  = 34;
    localparam int unsigned POS_SD   = 63;

    // Fields copied straight from write data on every write
    localparam int unsigned N_DIRECT = 11;
    localparam int unsigned DIRECT_LSB [N_DIRECT] = '{
        POS_SIE, POS_MIE, POS_SPIE, POS_MPIE, POS_FS, POS_MPRV,
        POS_SUM, POS_MXR, POS_TVM, POS_TW, POS_TSR
    };
    localparam int unsigned DIRECT_WID [N_DIRECT] = '{
        1, 1, 1, 1, 2, 1, 1, 1, 1, 1, 1
    };

    // Build the always-writable mask from the descriptor tables
    function automatic logic [STAT_W-1:0] build_direct_mask();
        logic [STAT_W-1:0] m;
        m = '0;
        for (int i = 0; i < int'(N_DIRECT); i++) begin
            for (int b = 0; b < int'(DIRECT_WID[i]); b++) begin
                m[DIRECT_LSB[i] + b] = 1'b1;
            end
        end
        return m;
    endfunction

    // Build a mask for a contiguous field
    function automatic logic [STAT_W-1:0] field_mask(int unsigned lsb,
                                                     int unsigned wid);
        logic [STAT_W-1:0] m;
        m = '0;
        for (int b = 0; b < int'(wid); b++) begin
            m[lsb + b] = 1'b1;
        end
        return m;
    endfunction

    localparam logic [STAT_W-1:0] DIRECT_MASK = build_direct_mask();
    localparam logic [STAT_W-1:0] SPP_MASK    = field_mask(POS_SPP, 1);
    localparam logic [STAT_W-1:0] XS_MASK     = field_mask(POS_XS, 2);
    localparam logic [STAT_W-1:0] MPP_MASK    = field_mask(POS_MPP, PRIV_W);
    localparam logic [STAT_W-1:0] XL_MASK     = field_mask(POS_UXL, XLFLD_W)
                                              | field_mask(POS_SXL, XLFLD_W);
    localparam logic [STAT_W-1:0] SD_MASK     = field_mask(POS_SD, 1);
    localparam logic [STAT_W-1:0] DEFINED_MASK = DIRECT_MASK | SPP_MASK
                                               | XS_MASK | MPP_MASK
                                               | XL_MASK | SD_MASK;

endpackage

// File: rtl/mstat_priv_legal.sv
// Module: mstat_priv_legal
// Maps a requested privilege code to one the core implements.
// Purely combinational. Assumes the configuration bits are static.
module mstat_priv_legal
    import mstat_pkg::*;
#(
    parameter int unsigned PW = PRIV_W
) (
    input  logic          has_user,
    input  logic          has_super,
    input  logic [PW-1:0] req_priv,
    output logic [PW-1:0] legal_priv
);

    // Apply the mode-availability rule to one request
    always_comb begin
        if (!has_user) begin
            legal_priv = PW'(PRIV_MACH);
        end else if (req_priv == PW'(PRIV_RSVD)) begin
            legal_priv = PW'(PRIV_USER);
        end else if ((req_priv == PW'(PRIV_SUPER)) && !has_super) begin
            legal_priv = PW'(PRIV_USER);
        end else begin
            legal_priv = req_priv;
        end
    end

endmodule

// File: rtl/mstat_merge.sv
// Module: mstat_merge
// Forms the value a status write commits: gated field merge, legalized
// MPP, forced width fields, derived SD and cleared undefined bits.
// Assumes old_stat already holds a legal value.
module mstat_merge
    import mstat_pkg::*;
#(
    parameter int unsigned DW        = STAT_W,
    parameter logic [1:0]  XL_ENC    = 2'b10
) (
    input  mstat_cfg_t        cfg,
    input  logic [DW-1:0]     old_stat,
    input  logic [DW-1:0]     wdata,
    input  logic [PRIV_W-1:0] legal_mpp,
    output logic [DW-1:0]     new_stat
);

    logic [DW-1:0] wr_mask;
    logic [DW-1:0] merged;

    // Assemble the write mask from static and configuration-gated parts
    always_comb begin
        wr_mask = DW'(DIRECT_MASK);
        if (cfg.has_super) begin
            wr_mask = wr_mask | DW'(SPP_MASK);
        end
        if (cfg.ext_xs) begin
            wr_mask = wr_mask | DW'(XS_MASK);
        end
    end

    // Merge, then overwrite the fields the block owns
    always_comb begin
        merged = (old_stat & ~wr_mask) | (wdata & wr_mask);
        merged[POS_MPP +: PRIV_W]  = legal_mpp;
        merged[POS_UXL +: XLFLD_W] = XL_ENC;
        merged[POS_SXL +: XLFLD_W] = XL_ENC;
        merged[POS_SD]             = &merged[POS_FS +: 2];
        new_stat = merged & DW'(DEFINED_MASK);
    end

endmodule

// File: rtl/mstat_csr.sv
// Module: mstat_csr
// Machine status register plus current privilege. Each write is legalized
// before it is stored, and a flush request follows every write.
// Assumes the cfg_* inputs change only while rst_n is low.
module mstat_csr
    import mstat_pkg::*;
#(
    parameter int unsigned DW     = STAT_W,
    parameter logic [1:0]  XL_ENC = 2'b10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_has_user,
    input  logic              cfg_has_super,
    input  logic              cfg_ext_xs,
    input  logic              csr_we,
    input  logic [DW-1:0]     csr_wdata,
    output logic [DW-1:0]     csr_rdata,
    input  logic              priv_we,
    input  logic [PRIV_W-1:0] priv_wdata,
    output logic [PRIV_W-1:0] priv_cur,
    output logic              tlb_flush
);

    localparam int unsigned N_LEG = 2;   // 0: MPP request, 1: mode change
    localparam logic [DW-1:0] RST_STAT =
        (DW'(PRIV_MACH) << POS_MPP) |
        (DW'(XL_ENC) << POS_UXL) |
        (DW'(XL_ENC) << POS_SXL);

    mstat_cfg_t        cfg;
    logic [DW-1:0]     stat_q;
    logic [DW-1:0]     stat_nxt;
    logic [PRIV_W-1:0] priv_q;
    logic              flush_q;
    logic [PRIV_W-1:0] leg_req [N_LEG];
    logic [PRIV_W-1:0] leg_out [N_LEG];

    // Bundle the static configuration
    always_comb begin
        cfg.has_user  = cfg_has_user;
        cfg.has_super = cfg_has_super;
        cfg.ext_xs    = cfg_ext_xs;
    end

    // Route the two privilege requests to their legalizers
    always_comb begin
        leg_req[0] = csr_wdata[POS_MPP +: PRIV_W];
        leg_req[1] = priv_wdata;
    end

    for (genvar g = 0; g < int'(N_LEG); g++) begin : g_leg
        mstat_priv_legal #(.PW(PRIV_W)) u_leg (
            .has_user   (cfg.has_user),
            .has_super  (cfg.has_super),
            .req_priv   (leg_req[g]),
            .legal_priv (leg_out[g])
        );
    end

    mstat_merge #(.DW(DW), .XL_ENC(XL_ENC)) u_merge (
        .cfg       (cfg),
        .old_stat  (stat_q),
        .wdata     (csr_wdata),
        .legal_mpp (leg_out[0]),
        .new_stat  (stat_nxt)
    );

    // Status register: reset value or committed write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= RST_STAT;
        end else if (csr_we) begin
            stat_q <= stat_nxt;
        end
    end

    // Current privilege: machine after reset, legalized on change
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            priv_q <= PRIV_W'(PRIV_MACH);
        end else if (priv_we) begin
            priv_q <= leg_out[1];
        end
    end

    // Flush request registered on the committing edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flush_q <= 1'b0;
        end else begin
            flush_q <= csr_we | priv_we;
        end
    end

    assign csr_rdata = stat_q;
    assign priv_cur  = priv_q;
    assign tlb_flush = flush_q;

endmodule

// File: rtl/mstat_csr_chk.sv
// Module: mstat_csr_chk
// Cycle-by-cycle invariants for mstat_csr, attached with bind.
// Assumes configuration changes only while reset is asserted.
module mstat_csr_chk
    import mstat_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_has_user,
    input logic              cfg_has_super,
    input logic              csr_we,
    input logic [STAT_W-1:0] csr_rdata,
    input logic              priv_we,
    input logic [PRIV_W-1:0] priv_cur,
    input logic              tlb_flush
);

    logic [PRIV_W-1:0] mpp_rd;
    assign mpp_rd = csr_rdata[POS_MPP +: PRIV_W];

    AST_MPP_NO_USER: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_has_user |-> (mpp_rd == 2'd3)); // R3
    AST_MPP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_has_user |-> (mpp_rd != 2'd2) &&
                         !((mpp_rd == 2'd1) && !cfg_has_super)); // R2
    AST_PRIV_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_has_user |-> (priv_cur == 2'd3)) and
        (cfg_has_user |-> (priv_cur != 2'd2) &&
                          !((priv_cur == 2'd1) && !cfg_has_super))); // R2
    AST_SPP_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_has_super |-> !csr_rdata[POS_SPP]); // R4
    AST_SD_FOLLOWS_FS: assert property (@(posedge clk) disable iff (!rst_n)
        csr_rdata[POS_SD] == (csr_rdata[POS_FS +: 2] == 2'b11)); // R7
    AST_XL_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_rdata[POS_UXL +: 2] == 2'b10) &&
        (csr_rdata[POS_SXL +: 2] == 2'b10)); // R8
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_rdata & ~DEFINED_MASK) == '0); // R10
    AST_FLUSH_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we || priv_we) |=> tlb_flush); // R9
    AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(csr_we || priv_we) |=> !tlb_flush); // R9
    AST_STAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !csr_we |=> $stable(csr_rdata)); // R11
    AST_PRIV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !priv_we |=> $stable(priv_cur)); // R11

endmodule

bind mstat_csr mstat_csr_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_has_user  (cfg_has_user),
    .cfg_has_super (cfg_has_super),
    .csr_we        (csr_we),
    .csr_rdata     (csr_rdata),
    .priv_we       (priv_we),
    .priv_cur      (priv_cur),
    .tlb_flush     (tlb_flush)
);

// File: tb/mstat_csr_bench.sv
// Scoreboard bench for mstat_csr: a driver pushes one expected item per
// cycle, and a monitor compares it one time unit after the committing edge.
module mstat_csr_bench;

    typedef struct {
        logic [63:0] stat;
        logic [1:0]  priv;
        logic        flush;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_has_user = 1'b1;
    logic        cfg_has_super = 1'b1;
    logic        cfg_ext_xs = 1'b1;
    logic        csr_we = 1'b0;
    logic [63:0] csr_wdata = '0;
    logic [63:0] csr_rdata;
    logic        priv_we = 1'b0;
    logic [1:0]  priv_wdata = '0;
    logic [1:0]  priv_cur;
    logic        tlb_flush;

    int   n_run  = 0;
    int   n_fail = 0;
    exp_t sb_q[$];
    logic [63:0] m_stat;
    logic [1:0]  m_priv;

    always #2.5 clk = ~clk;   // 200 MHz

    mstat_csr u_mstat_csr (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_has_user  (cfg_has_user),
        .cfg_has_super (cfg_has_super),
        .cfg_ext_xs    (cfg_ext_xs),
        .csr_we        (csr_we),
        .csr_wdata     (csr_wdata),
        .csr_rdata     (csr_rdata),
        .priv_we       (priv_we),
        .priv_wdata    (priv_wdata),
        .priv_cur      (priv_cur),
        .tlb_flush     (tlb_flush)
    );

    // Privilege rule as written in R2
    function automatic logic [1:0] legal(input logic [1:0] r);
        if (!cfg_has_user) return 2'd3;
        if (r == 2'd2) return 2'd0;
        if (r == 2'd1 && !cfg_has_super) return 2'd0;
        return r;
    endfunction

    // Expected status after a write, per R3..R8 and R10
    function automatic logic [63:0] model_write(input logic [63:0] o,
                                                input logic [63:0] w);
        logic [63:0] n;
        n = '0;
        n[1] = w[1];  n[3] = w[3];  n[5] = w[5];  n[7] = w[7];
        n[14:13] = w[14:13];
        n[22:17] = w[22:17];
        n[8]     = cfg_has_super ? w[8] : o[8];
        n[16:15] = cfg_ext_xs ? w[16:15] : o[16:15];
        n[12:11] = legal(w[12:11]);
        n[33:32] = 2'b10;
        n[35:34] = 2'b10;
        n[63]    = (n[14:13] == 2'b11);
        return n;
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Driver: one cycle of stimulus and its expected result
    task automatic step(input logic we, input logic [63:0] wd,
                        input logic pwe, input logic [1:0] pwd,
                        input string tag);
        exp_t e;
        @(negedge clk);
        csr_we = we; csr_wdata = wd; priv_we = pwe; priv_wdata = pwd;
        if (we)  m_stat = model_write(m_stat, wd);
        if (pwe) m_priv = legal(pwd);
        e.stat = m_stat; e.priv = m_priv; e.flush = we | pwe; e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic idle_end();
        @(negedge clk);
        csr_we = 1'b0; priv_we = 1'b0;
        wait (sb_q.size() == 0);
    endtask

    // Reset with a new configuration and check the reset state (R1)
    task automatic do_reset(input logic u, input logic s, input logic x);
        @(negedge clk);
        rst_n = 1'b0; csr_we = 1'b0; priv_we = 1'b0;
        cfg_has_user = u; cfg_has_super = s; cfg_ext_xs = x;
        repeat (2) @(negedge clk);
        check("R1", "reset stat", csr_rdata, 64'h0000_000A_0000_1800);
        check("R1", "reset priv", {62'd0, priv_cur}, 64'd3);
        check("R1", "reset flush", {63'd0, tlb_flush}, 64'd0);
        m_stat = 64'h0000_000A_0000_1800;
        m_priv = 2'd3;
        rst_n = 1'b1;
    endtask

    // Monitor: compare after each committing edge
    always begin
        @(posedge clk);
        #1;
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            check(e.tag, "stat", csr_rdata, e.stat);
            check(e.tag, "priv", {62'd0, priv_cur}, {62'd0, e.priv});
            check(e.tag, "flush", {63'd0, tlb_flush}, {63'd0, e.flush});
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // Configuration A: user, supervisor and extension present
        do_reset(1'b1, 1'b1, 1'b1);
        step(1, '1, 0, 2'd0, "R5");                   // all fields, SD set (R7)
        step(0, '0, 0, 2'd0, "R11");                  // hold, no flush (R9)
        step(1, 64'h0, 0, 2'd0, "R10");               // clear, MPP 0 legal
        step(1, 64'h0000_0000_0000_1000, 0, 2'd0, "R3"); // MPP=2 -> 0
        step(1, 64'h0000_0000_0000_0800, 0, 2'd0, "R3"); // MPP=1 kept
        step(1, 64'h5555_5555_5555_5555, 0, 2'd0, "R8");
        step(1, 64'hAAAA_AAAA_AAAA_AAAA, 0, 2'd0, "R6");
        step(1, 64'h0000_0000_0000_2100, 0, 2'd0, "R7"); // FS=01, SPP=1 (R4)
        step(0, '1, 1, 2'd2, "R2");                   // reserved -> user
        step(0, '1, 1, 2'd1, "R2");                   // super kept
        step(0, '1, 0, 2'd3, "R9");                   // no write, no flush
        step(0, '1, 1, 2'd3, "R2");
        idle_end();
        // Configuration B: user only, no extension
        do_reset(1'b1, 1'b0, 1'b0);
        step(1, '1, 0, 2'd0, "R4");                   // SPP and XS stay 0 (R6)
        step(1, 64'h0000_0000_0000_0800, 0, 2'd0, "R3"); // MPP=1 -> 0
        step(1, 64'hFFFF_FFFF_FF80_0000, 0, 2'd0, "R10");
        step(0, '0, 1, 2'd1, "R2");                   // super -> user
        step(1, 64'h0000_0000_0000_6000, 1, 2'd3, "R7");
        step(0, '0, 0, 2'd0, "R11");
        idle_end();
        // Configuration C: machine only
        do_reset(1'b0, 1'b0, 1'b0);
        step(1, 64'h0, 0, 2'd0, "R3");                // MPP=0 -> 3
        step(0, '0, 1, 2'd0, "R2");                   // user -> machine
        step(1, 64'h0000_0003_0000_1000, 0, 2'd0, "R8");
        idle_end();
        #10;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule